// File: doc/BRIEF.md
# Multithreaded Warp Issue Scheduler

This block picks one warp per issue opportunity from a fixed pool of resident warps and starts dispatching its next instruction. A warp can be picked only when it is resident (valid) and an external scoreboard reports that the operands of its next instruction are ready. When several warps qualify, the one with the highest priority wins. Among warps that share the top priority, a rotating order starting just after the most recently granted warp breaks the tie.

One grant occupies the dispatch path for a fixed number of cycles. During that time the same instruction is fed to successive lane groups of the warp, and a beat counter names the group being fed. No new grant is made while a dispatch is in flight. The next grant can be registered at the clock edge that ends the last beat, so consecutive dispatches run without an idle cycle, even when the warp changes. The scheduler also forwards the program-counter tag of the chosen warp, captured at the grant edge, so that downstream logic knows which instruction the granted warp is executing.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted and after it is released with no eligible warp, issue_strobe, dispatch_busy, grant_id, issue_pc and dispatch_beat are all zero.
- R2: A grant is made only to a warp with both warp_valid and warp_ready set at the grant edge. When no warp has both bits set, issue_strobe stays low.
- R3: Priority is a 2-bit field per warp, with warp w at bits [2w+1:2w] of warp_prio. The value 3 is the highest. Among eligible warps, the one granted always has the largest priority value present.
- R4: Among eligible warps with the top priority, the grant goes to the first one found in ascending warp order, with wrap-around, starting at the warp after the last granted one. After reset the search starts at warp 0.
- R5: A grant decided at an edge shows up in the following cycle as issue_strobe high for one cycle. dispatch_busy is then high for exactly 4 cycles, with dispatch_beat counting 0,1,2,3. grant_id and issue_pc hold steady for the whole dispatch.
- R6: No grant is made while dispatch_beat is below 3. A grant can be made at the edge that ends beat 3, so that dispatch_busy stays high and the new issue_strobe follows beat 3 with no gap.
- R7: When no warp is eligible at an arbitration edge, no grant is made and the round-robin position is kept. The next tie-break resumes after the warp that was last granted.
- R8: Eligibility is sampled only at the arbitration edge. A warp whose valid bit is cleared in the cycle before that edge is excluded, even if it was valid earlier in the dispatch.
- R9: issue_pc equals bits [12w+11:12w] of warp_pc for the granted warp w, sampled at the grant edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_valid | input | 16 | Per-warp resident flag |
| warp_ready | input | 16 | Per-warp operands-ready flag from the scoreboard |
| warp_prio | input | 32 | Per-warp 2-bit priority, warp w at bits [2w+1:2w] |
| warp_pc | input | 192 | Per-warp 12-bit program counter tag, warp w at bits [12w+11:12w] |
| issue_strobe | output | 1 | One-cycle pulse in the first beat of a new dispatch |
| grant_id | output | 4 | Warp being dispatched |
| issue_pc | output | 12 | Program counter tag of the dispatched warp |
| dispatch_busy | output | 1 | High while a dispatch occupies the lanes |
| dispatch_beat | output | 2 | Lane group fed in the current cycle |

## Verification
If the beat counter drifts, the next issue_strobe shows up early or late against the 4-beat rhythm in the very next dispatch window. A stale or misplaced round-robin pointer shows up as the wrong grant_id at the next tie between equal-priority warps. That can happen one grant later, or only after an idle stretch if the hold-on-idle logic is broken. A scoreboard predicts strobe, warp, tag, busy and beat for every cycle. It therefore catches a fault in the first cycle it becomes visible, including faults that only change the order of grants.

// File: rtl/wis_pkg.sv
package wis_pkg;

   // Dispatch path occupancy
   typedef enum logic {
      DSP_IDLE = 1'b0,
      DSP_BUSY = 1'b1
   } dsp_state_e;

   // Width of a counter or index that must be at least one bit wide
   function automatic int idx_width(input int count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

   // True when v is a power of two and at least 2
   function automatic bit is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wis_prio_filter.sv
// Keeps only those eligible warps whose priority equals the largest present.
module wis_prio_filter #(
   parameter int NUM_WARPS = 16,
   parameter int PRIO_W    = 2
) (
   input  logic [NUM_WARPS-1:0]        elig,
   input  logic [NUM_WARPS*PRIO_W-1:0] prio,
   output logic [NUM_WARPS-1:0]        top_mask
);

   logic [PRIO_W-1:0] top_lvl;

   always_comb begin
      top_lvl = '0;
      for (int w = 0; w < NUM_WARPS; w++) begin
         if (elig[w] && (prio[w*PRIO_W +: PRIO_W] > top_lvl))
            top_lvl = prio[w*PRIO_W +: PRIO_W];
      end
   end

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_mask
      assign top_mask[w] = elig[w] && (prio[w*PRIO_W +: PRIO_W] == top_lvl);
   end

endmodule

// File: rtl/wis_rr_pick.sv
// Rotating search: first set bit of cand at or after last_id+1, wrapping.
module wis_rr_pick #(
   parameter int NUM_WARPS = 16,
   localparam int IDW      = wis_pkg::idx_width(NUM_WARPS)
) (
   input  logic [NUM_WARPS-1:0] cand,
   input  logic [IDW-1:0]       last_id,
   output logic                 found,
   output logic [IDW-1:0]       pick_id
);

   logic [IDW-1:0] probe;

   always_comb begin
      found   = 1'b0;
      pick_id = last_id;
      probe   = last_id;
      for (int i = 1; i <= NUM_WARPS; i++) begin
         probe = last_id + IDW'(i);
         if (!found && cand[probe]) begin
            found   = 1'b1;
            pick_id = probe;
         end
      end
   end

endmodule

// File: rtl/wis_dispatch_ctrl.sv
// Tracks how many lane-group beats of the current dispatch remain.
module wis_dispatch_ctrl #(
   parameter int ISSUE_CYCLES = 4,
   localparam int BEAT_W      = wis_pkg::idx_width(ISSUE_CYCLES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [BEAT_W-1:0] beat,
   output logic              can_accept
);
   import wis_pkg::*;

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(ISSUE_CYCLES - 1);

   dsp_state_e state_q;

   assign busy = (state_q == DSP_BUSY);

   if (ISSUE_CYCLES == 1) begin : g_single
      // Every dispatch is one beat: the path frees itself each cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) state_q <= DSP_IDLE;
         else        state_q <= start ? DSP_BUSY : DSP_IDLE;
      end
      assign beat       = '0;
      assign can_accept = 1'b1;
   end else begin : g_multi
      logic [BEAT_W-1:0] beat_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            state_q <= DSP_IDLE;
            beat_q  <= '0;
         end else if (start) begin
            state_q <= DSP_BUSY;
            beat_q  <= '0;
         end else if (state_q == DSP_BUSY) begin
            if (beat_q == LAST_BEAT) begin
               state_q <= DSP_IDLE;
               beat_q  <= '0;
            end else begin
               beat_q  <= beat_q + 1'b1;
            end
         end
      end

      assign beat       = beat_q;
      assign can_accept = (state_q == DSP_IDLE) || (beat_q == LAST_BEAT);
   end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
   parameter int NUM_WARPS    = 16,
   parameter int PRIO_W       = 2,
   parameter int PC_W         = 12,
   parameter int ISSUE_CYCLES = 4,
   localparam int IDW         = wis_pkg::idx_width(NUM_WARPS),
   localparam int BEAT_W      = wis_pkg::idx_width(ISSUE_CYCLES)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_WARPS-1:0]        warp_valid,
   input  logic [NUM_WARPS-1:0]        warp_ready,
   input  logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
   input  logic [NUM_WARPS*PC_W-1:0]   warp_pc,
   output logic                        issue_strobe,
   output logic [IDW-1:0]              grant_id,
   output logic [PC_W-1:0]             issue_pc,
   output logic                        dispatch_busy,
   output logic [BEAT_W-1:0]           dispatch_beat
);

   // Elaboration-time parameter checks
   if (!wis_pkg::is_pow2(NUM_WARPS)) begin : g_bad_warps
      initial $fatal(1, "NUM_WARPS must be a power of two, at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      initial $fatal(1, "PRIO_W must be at least 1");
   end
   if (PC_W < 1) begin : g_bad_pc
      initial $fatal(1, "PC_W must be at least 1");
   end
   if (ISSUE_CYCLES < 1) begin : g_bad_cycles
      initial $fatal(1, "ISSUE_CYCLES must be at least 1");
   end

   logic [NUM_WARPS-1:0] elig;
   logic [NUM_WARPS-1:0] top_mask;
   logic                 any_top;
   logic [IDW-1:0]       pick_id;
   logic [IDW-1:0]       rr_last_q;
   logic                 can_accept;
   logic                 start;

   assign elig = warp_valid & warp_ready;

   wis_prio_filter #(
      .NUM_WARPS (NUM_WARPS),
      .PRIO_W    (PRIO_W)
   ) u_filter (
      .elig     (elig),
      .prio     (warp_prio),
      .top_mask (top_mask)
   );

   wis_rr_pick #(
      .NUM_WARPS (NUM_WARPS)
   ) u_pick (
      .cand    (top_mask),
      .last_id (rr_last_q),
      .found   (any_top),
      .pick_id (pick_id)
   );

   wis_dispatch_ctrl #(
      .ISSUE_CYCLES (ISSUE_CYCLES)
   ) u_dsp (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .busy       (dispatch_busy),
      .beat       (dispatch_beat),
      .can_accept (can_accept)
   );

   assign start = can_accept && any_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         issue_strobe <= 1'b0;
         grant_id     <= '0;
         issue_pc     <= '0;
         rr_last_q    <= IDW'(NUM_WARPS - 1);
      end else begin
         issue_strobe <= start;
         if (start) begin
            grant_id  <= pick_id;
            issue_pc  <= warp_pc[pick_id*PC_W +: PC_W];
            rr_last_q <= pick_id;
         end
      end
   end

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
   parameter int NUM_WARPS    = 16,
   parameter int PRIO_W       = 2,
   parameter int PC_W         = 12,
   parameter int ISSUE_CYCLES = 4,
   localparam int IDW         = wis_pkg::idx_width(NUM_WARPS),
   localparam int BEAT_W      = wis_pkg::idx_width(ISSUE_CYCLES)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_WARPS-1:0]        warp_valid,
   input logic [NUM_WARPS-1:0]        warp_ready,
   input logic [NUM_WARPS*PRIO_W-1:0] warp_prio,
   input logic [NUM_WARPS*PC_W-1:0]   warp_pc,
   input logic                        issue_strobe,
   input logic [IDW-1:0]              grant_id,
   input logic [PC_W-1:0]             issue_pc,
   input logic                        dispatch_busy,
   input logic [BEAT_W-1:0]           dispatch_beat
);

   localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(ISSUE_CYCLES - 1);

   logic [NUM_WARPS-1:0]        elig_now;
   logic [NUM_WARPS-1:0]        elig_q;
   logic [NUM_WARPS*PRIO_W-1:0] prio_q;
   logic [NUM_WARPS*PC_W-1:0]   pc_q;
   logic [PRIO_W-1:0]           top_now;
   logic [PRIO_W-1:0]           top_q;
   logic                        arb_slot;

   assign elig_now = warp_valid & warp_ready;
   assign arb_slot = !dispatch_busy || (dispatch_beat == LAST_BEAT);

   always_comb begin
      top_now = '0;
      for (int w = 0; w < NUM_WARPS; w++)
         if (elig_now[w] && warp_prio[w*PRIO_W +: PRIO_W] > top_now)
            top_now = warp_prio[w*PRIO_W +: PRIO_W];
   end

   always_ff @(posedge clk) begin
      elig_q <= elig_now;
      prio_q <= warp_prio;
      pc_q   <= warp_pc;
      top_q  <= top_now;
   end

   // R2: the granted warp was eligible at the grant edge
   a_r2_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
      issue_strobe |-> elig_q[grant_id]);

   // R2: nothing eligible in an arbitration slot means no strobe next
   a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_slot && (elig_now == '0)) |=> !issue_strobe);

   // R3: the granted warp carries the highest eligible priority
   a_r3_top_priority: assert property (@(posedge clk) disable iff (!rst_n)
      issue_strobe |-> (prio_q[grant_id*PRIO_W +: PRIO_W] == top_q));

   // R5: a strobe marks the first beat of a busy window
   a_r5_strobe_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      issue_strobe |-> (dispatch_busy && dispatch_beat == '0));

   // R5: mid-dispatch beats advance by one with grant and tag held
   a_r5_beat_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (dispatch_busy && dispatch_beat != LAST_BEAT) |=>
         (dispatch_busy && !issue_strobe &&
          dispatch_beat == $past(dispatch_beat) + 1'b1 &&
          $stable(grant_id) && $stable(issue_pc)));

   // R6: an eligible warp at the last beat is granted with no gap
   a_r6_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_slot && (elig_now != '0)) |=> issue_strobe);

   // R9: the issued tag is the one presented by the warp at the grant edge
   a_r9_pc_capture: assert property (@(posedge clk) disable iff (!rst_n)
      issue_strobe |-> (issue_pc == pc_q[grant_id*PC_W +: PC_W]));

endmodule

bind warp_issue_sched wis_checker #(
   .NUM_WARPS    (NUM_WARPS),
   .PRIO_W       (PRIO_W),
   .PC_W         (PC_W),
   .ISSUE_CYCLES (ISSUE_CYCLES)
) u_wis_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .warp_valid    (warp_valid),
   .warp_ready    (warp_ready),
   .warp_prio     (warp_prio),
   .warp_pc       (warp_pc),
   .issue_strobe  (issue_strobe),
   .grant_id      (grant_id),
   .issue_pc      (issue_pc),
   .dispatch_busy (dispatch_busy),
   .dispatch_beat (dispatch_beat)
);

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;

   localparam int N   = 16;
   localparam int PW  = 2;
   localparam int PCW = 12;
   localparam int IC  = 4;
   localparam int IDW = 4;
   localparam int BW  = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      warp_valid = '0;
   logic [N-1:0]      warp_ready = '0;
   logic [N*PW-1:0]   warp_prio  = '0;
   logic [N*PCW-1:0]  warp_pc    = '0;
   logic              issue_strobe;
   logic [IDW-1:0]    grant_id;
   logic [PCW-1:0]    issue_pc;
   logic              dispatch_busy;
   logic [BW-1:0]     dispatch_beat;

   always #4 clk = ~clk;   // 125 MHz

   warp_issue_sched #(
      .NUM_WARPS(N), .PRIO_W(PW), .PC_W(PCW), .ISSUE_CYCLES(IC)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .warp_valid(warp_valid), .warp_ready(warp_ready),
      .warp_prio(warp_prio), .warp_pc(warp_pc),
      .issue_strobe(issue_strobe), .grant_id(grant_id), .issue_pc(issue_pc),
      .dispatch_busy(dispatch_busy), .dispatch_beat(dispatch_beat)
   );

   typedef struct {
      int due;
      bit stb;
      int id;
      int pc;
      bit busy;
      int beat;
      int req;
   } exp_t;

   exp_t q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   pe      = 0;
   bit   done    = 1'b0;

   // Reference model state
   int m_rem = 0;
   int m_ptr = N - 1;
   int m_id  = 0;
   int m_pc  = 0;

   always @(posedge clk) pe <= pe + 1;

   // Monitor: compares outputs to the expected item due this cycle
   always @(negedge clk) begin
      if (q.size() > 0 && q[0].due == pe) begin
         exp_t e;
         e = q.pop_front();
         n_tests++;
         if (issue_strobe !== e.stb || int'(grant_id) != e.id ||
             int'(issue_pc) != e.pc || dispatch_busy !== e.busy ||
             int'(dispatch_beat) != e.beat) begin
            n_fail++;
            $display("FAIL R%0d cyc %0d: actual stb=%0b id=%0d pc=%0h busy=%0b beat=%0d expected stb=%0b id=%0d pc=%0h busy=%0b beat=%0d",
                     e.req, pe, issue_strobe, grant_id, issue_pc, dispatch_busy,
                     dispatch_beat, e.stb, e.id, e.pc, e.busy, e.beat);
         end
      end
   end

   function automatic logic [N*PW-1:0] prio_all(input int lvl);
      logic [N*PW-1:0] r;
      for (int w = 0; w < N; w++) r[w*PW +: PW] = PW'(lvl);
      return r;
   endfunction

   function automatic logic [N*PCW-1:0] rnd_pc();
      logic [N*PCW-1:0] r;
      for (int w = 0; w < N; w++) r[w*PCW +: PCW] = PCW'($urandom);
      return r;
   endfunction

   function automatic logic [N*PW-1:0] rnd_prio();
      logic [N*PW-1:0] r;
      for (int w = 0; w < N; w++) r[w*PW +: PW] = PW'($urandom);
      return r;
   endfunction

   // Driver: applies one cycle of inputs and predicts the next cycle
   task automatic step(input logic [N-1:0] v, input logic [N-1:0] r,
                       input logic [N*PW-1:0] p, input logic [N*PCW-1:0] pcv,
                       input int req);
      logic [N-1:0] el;
      int top, pick, idx;
      bit grant;
      exp_t e;
      @(posedge clk);
      #2;
      warp_valid = v;
      warp_ready = r;
      warp_prio  = p;
      warp_pc    = pcv;
      el   = v & r;
      top  = -1;
      pick = -1;
      for (int w = 0; w < N; w++)
         if (el[w] && int'(p[w*PW +: PW]) > top) top = int'(p[w*PW +: PW]);
      for (int i = 1; i <= N; i++) begin
         idx = (m_ptr + i) % N;
         if (pick < 0 && el[idx] && int'(p[idx*PW +: PW]) == top) pick = idx;
      end
      grant = (m_rem <= 1) && (pick >= 0);
      if (grant) begin
         m_rem = IC;
         m_ptr = pick;
         m_id  = pick;
         m_pc  = int'(pcv[pick*PCW +: PCW]);
      end else if (m_rem > 0) begin
         m_rem = m_rem - 1;
      end
      e.due  = pe + 1;
      e.stb  = grant;
      e.id   = m_id;
      e.pc   = m_pc;
      e.busy = (m_rem > 0);
      e.beat = (m_rem > 0) ? IC - m_rem : 0;
      e.req  = req;
      q.push_back(e);
   endtask

   initial begin : watchdog
      #(8 * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [N-1:0] v;
      // R1: reset state
      repeat (3) @(negedge clk);
      n_tests++;
      if (issue_strobe !== 1'b0 || dispatch_busy !== 1'b0 || grant_id !== '0 ||
          issue_pc !== '0 || dispatch_beat !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: actual stb=%0b busy=%0b id=%0d pc=%0h beat=%0d expected all zero",
                  issue_strobe, dispatch_busy, grant_id, issue_pc, dispatch_beat);
      end
      rst_n = 1'b1;

      // R1: still idle after release with nothing eligible
      repeat (3) step('0, '0, '0, '0, 1);

      // R2: ready without valid, and valid without ready, never granted
      repeat (5) step(16'h0080, 16'hFF7F, '0, rnd_pc(), 2);
      repeat (4) step(16'hFFFF, '0, prio_all(3), rnd_pc(), 2);

      // R5: single eligible warp 5, repeated 4-beat dispatches
      repeat (12) step(16'hFFFF, 16'h0020, '0, rnd_pc(), 5);

      // R4: all warps eligible at equal priority, rotating order
      repeat (40) step(16'hFFFF, 16'hFFFF, prio_all(1), rnd_pc(), 4);

      // R6: back-to-back dispatches with a changing eligible set
      for (int k = 0; k < 24; k++)
         step(16'hFFFF, (k % 2 == 0) ? 16'h0F0F : 16'hF0F0, prio_all(2), rnd_pc(), 6);

      // R3: warps 2 and 9 at priority 3, the rest at 1
      begin
         logic [N*PW-1:0] p;
         p = prio_all(1);
         p[2*PW +: PW] = 2'd3;
         p[9*PW +: PW] = 2'd3;
         repeat (24) step(16'hFFFF, 16'hFFFF, p, rnd_pc(), 3);
         // R3: priority 0 warps lose to a lone priority 2 warp
         p = '0;
         p[12*PW +: PW] = 2'd2;
         repeat (12) step(16'hFFFF, 16'hFFFF, p, rnd_pc(), 3);
      end

      // R8: the warp next in line drops its valid bit every cycle
      for (int k = 0; k < 24; k++) begin
         v = 16'hFFFF;
         v[(m_ptr + 1) % N] = 1'b0;
         step(v, 16'hFFFF, prio_all(0), rnd_pc(), 8);
      end

      // R7: grant warp 3, go idle, then resume rotation after warp 3
      step(16'h0008, 16'hFFFF, '0, rnd_pc(), 7);
      repeat (9) step('0, 16'hFFFF, '0, rnd_pc(), 7);
      repeat (8) step(16'hFFFF, 16'hFFFF, '0, rnd_pc(), 7);

      // R9: random traffic, checking captured tags and everything else
      for (int k = 0; k < 400; k++)
         step(N'($urandom), N'($urandom), rnd_prio(), rnd_pc(), 9);

      // Drain
      repeat (6) step('0, '0, '0, '0, 2);
      repeat (3) @(negedge clk);
      n_tests++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R5 drain: actual %0d pending expected 0", q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule